// File: doc/BRIEF.md
# Periodic Interrupt Divider

This block turns a 32.768 kHz clock-enable pulse into periodic events at a power-of-two rate chosen by a 4-bit rate code. A free-running 15-bit tick counter advances on every tick whether or not the generator is enabled. An event fires on a tick whose new count is a whole multiple of the selected period. Because of this, events stay locked to the same phase when software changes the rate, rather than restarting from the moment of the change.

Each event produces a one-clock pulse that tells the surrounding status logic to set its periodic flag. The same event drives an interrupt-request contribution when periodic interrupts are enabled, and a one-clock square-wave pulse when the square-wave output is enabled. The square-wave output is a single pulse per event, not a 50% duty waveform. Status storage, flag clearing, bus decoding and interrupt sharing belong to the surrounding logic.

Top module: `periodic_irq_divider`

## Requirements
- R1: While reset is asserted, and after its release until the first event, all three outputs are low; reset sets the tick count to zero.
- R2: With rate code 0, no output ever pulses, whatever the enable bits.
- R3: For a rate code n from 3 to 15, the period is 2^(n-1) ticks. An event fires on the tick that makes the tick count since reset a multiple of that period.
- R4: Rate code 1 gives a period of 128 ticks and rate code 2 gives 256 ticks, the same as codes 8 and 9.
- R5: When both `pieEn` and `sqwEn` are low, no output pulses, even with a nonzero rate code.
- R6: The tick count advances on every tick, including while the generator is disabled. After any change of rate code or enables, the next event falls on a multiple of the new period on that count.
- R7: `flagPulse` pulses on every event of a running generator. `irqPulse` pulses with it only when `pieEn` is high.
- R8: `sqwPulse` pulses with `flagPulse` when `sqwEn` is high, and never otherwise.
- R9: Outputs pulse only in the clock cycle right after a cycle with `tick` high. Changing the rate code or enables between ticks causes no pulse.
- R10: Every output pulse lasts exactly one clock cycle when ticks are separated by idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 32.768 kHz clock enable |
| rateCode | input | 4 | Rate select code (0 = off) |
| pieEn | input | 1 | Periodic interrupt enable |
| sqwEn | input | 1 | Square-wave output enable |
| flagPulse | output | 1 | Request to set the periodic flag |
| irqPulse | output | 1 | Interrupt-request contribution |
| sqwPulse | output | 1 | Square-wave output pulse |

## Verification
The checker verifies the gating rules on every cycle:
- no pulse without a preceding tick;
- no pulse under rate code 0 or with both enables low;
- the interrupt pulse appears only together with the flag pulse and only when interrupts are enabled;
- the square-wave pulse appears only together with the flag pulse and only when the square-wave output is enabled.

Only the bench scenarios show the timing behaviour. They compare the output against an independent tick count and show that the period matches the code, that codes 1 and 2 alias to longer periods, and that phase alignment survives rate changes and disabled stretches.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 15;

  // Strobes from control to datapath
  typedef struct packed {
    logic              run;
    logic              pieOn;
    logic              sqwOn;
    logic [CODE_W-1:0] effCode;
  } ctrlStrobes_t;
endpackage

// File: rtl/pid_ctrl.sv
module pid_ctrl
  import pid_pkg::*;
#(
  parameter int ALIAS1_CODE = 8,
  parameter int ALIAS2_CODE = 9
) (
  input  logic [CODE_W-1:0] rateCode,
  input  logic              pieEn,
  input  logic              sqwEn,
  output ctrlStrobes_t      strobes
);
  logic [CODE_W-1:0] effCode;

  // Short codes map onto slower rates
  always_comb begin
    case (rateCode)
      CODE_W'(1): effCode = CODE_W'(ALIAS1_CODE);
      CODE_W'(2): effCode = CODE_W'(ALIAS2_CODE);
      default:    effCode = rateCode;
    endcase
  end

  always_comb begin
    strobes.effCode = effCode;
    strobes.run     = (rateCode != '0) && (pieEn || sqwEn);
    strobes.pieOn   = pieEn;
    strobes.sqwOn   = sqwEn;
  end
endmodule

// File: rtl/pid_datapath.sv
module pid_datapath
  import pid_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  ctrlStrobes_t strobes,
  output logic         flagPulse,
  output logic         irqPulse,
  output logic         sqwPulse
);
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] lowMask;
  logic             wrapHit;
  logic             eventHit;

  assign nextCnt = tickCnt + CNT_W'(1);

  // Mask bit i is set when i lies below (effCode - 1)
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign lowMask[i] = int'(strobes.effCode) > (i + 1);
  end

  assign wrapHit  = (nextCnt & lowMask) == '0;
  assign eventHit = tick && strobes.run && wrapHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (tick) begin
      tickCnt <= nextCnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagPulse <= 1'b0;
      irqPulse  <= 1'b0;
      sqwPulse  <= 1'b0;
    end else begin
      flagPulse <= eventHit;
      irqPulse  <= eventHit && strobes.pieOn;
      sqwPulse  <= eventHit && strobes.sqwOn;
    end
  end
endmodule

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider
  import pid_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [CODE_W-1:0] rateCode,
  input  logic              pieEn,
  input  logic              sqwEn,
  output logic              flagPulse,
  output logic              irqPulse,
  output logic              sqwPulse
);
  ctrlStrobes_t strobes;

  pid_ctrl u_ctrl (
    .rateCode (rateCode),
    .pieEn    (pieEn),
    .sqwEn    (sqwEn),
    .strobes  (strobes)
  );

  pid_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .strobes   (strobes),
    .flagPulse (flagPulse),
    .irqPulse  (irqPulse),
    .sqwPulse  (sqwPulse)
  );
endmodule

// File: rtl/periodic_irq_divider_chk.sv
module periodic_irq_divider_chk
  import pid_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic [CODE_W-1:0] rateCode,
  input logic              pieEn,
  input logic              sqwEn,
  input logic              flagPulse,
  input logic              irqPulse,
  input logic              sqwPulse
);
  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (flagPulse || irqPulse || sqwPulse) |-> $past(tick)); // R9
  AST_CODE_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    flagPulse |-> ($past(rateCode) != '0)); // R2
  AST_ENABLE_NEEDED: assert property (@(posedge clk) disable iff (!rstN)
    flagPulse |-> ($past(pieEn) || $past(sqwEn))); // R5
  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (flagPulse && $past(pieEn))); // R7
  AST_FLAG_GIVES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (flagPulse && $past(pieEn)) |-> irqPulse); // R7
  AST_SQW_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    sqwPulse |-> (flagPulse && $past(sqwEn))); // R8
  AST_FLAG_GIVES_SQW: assert property (@(posedge clk) disable iff (!rstN)
    (flagPulse && $past(sqwEn)) |-> sqwPulse); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rstN) |-> !(flagPulse || irqPulse || sqwPulse)); // R1
endmodule

bind periodic_irq_divider periodic_irq_divider_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .rateCode  (rateCode),
  .pieEn     (pieEn),
  .sqwEn     (sqwEn),
  .flagPulse (flagPulse),
  .irqPulse  (irqPulse),
  .sqwPulse  (sqwPulse)
);

// File: tb/periodic_irq_divider_bench.sv
`timescale 1ns/1ps
module periodic_irq_divider_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] rateCode = 4'd0;
  logic       pieEn = 1'b0;
  logic       sqwEn = 1'b0;
  logic       flagPulse, irqPulse, sqwPulse;

  int checks = 0;
  int fails = 0;
  int model = 0;      // ticks since reset
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  periodic_irq_divider u_periodic_irq_divider (
    .clk(clk), .rstN(rstN), .tick(tick), .rateCode(rateCode),
    .pieEn(pieEn), .sqwEn(sqwEn),
    .flagPulse(flagPulse), .irqPulse(irqPulse), .sqwPulse(sqwPulse)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int periodOf(int code);
    int e;
    e = (code == 1) ? 8 : (code == 2) ? 9 : code;
    return 1 << (e - 1);
  endfunction

  task automatic checkOut(string tag, logic eF, logic eI, logic eS);
    checks++;
    if (flagPulse !== eF || irqPulse !== eI || sqwPulse !== eS) begin
      fails++;
      $display("FAIL %s: tick %0d code %0d flag/irq/sqw actual %b%b%b expected %b%b%b",
               tag, model, rateCode, flagPulse, irqPulse, sqwPulse, eF, eI, eS);
    end
  endtask

  // One tick followed by one idle cycle; checks both cycles
  task automatic tickOnce(string tag);
    bit hit;
    hit = (rateCode != 0) && (pieEn || sqwEn) &&
          (((model + 1) % periodOf(int'(rateCode))) == 0);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    checkOut(tag, hit, hit && pieEn, hit && sqwEn);
    @(negedge clk);
    checkOut("R10", 1'b0, 1'b0, 1'b0);
    model++;
  endtask

  task automatic runTicks(string tag, int n, int code, bit pie, bit sqw);
    rateCode = 4'(code);
    pieEn = pie;
    sqwEn = sqw;
    for (int k = 0; k < n; k++) tickOnce(tag);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    checkOut("R1", 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    rateCode = 4'd3; pieEn = 1'b1; sqwEn = 1'b1;
    @(negedge clk);
    checkOut("R1", 1'b0, 1'b0, 1'b0);
    // first event with period 4 is at tick 4, so ticks 1..3 are silent
    for (int k = 0; k < 3; k++) tickOnce("R1");
  endtask

  task automatic testQuietChange();
    // change rates between ticks: nothing may pulse
    for (int c = 0; c < 16; c++) begin
      rateCode = 4'(c); pieEn = c[0]; sqwEn = c[1];
      @(negedge clk);
      checkOut("R9", 1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    testReset();
    runTicks("R3", 16, 3, 1'b1, 1'b0);       // period 4, irq only
    runTicks("R7", 12, 4, 1'b1, 1'b0);       // period 8 with irq
    runTicks("R2", 20, 0, 1'b1, 1'b1);       // disabled, count still runs
    runTicks("R6", 21, 3, 1'b1, 1'b1);       // realigned after disable
    runTicks("R8", 70, 6, 1'b0, 1'b1);       // period 32, sqw only
    runTicks("R5", 40, 5, 1'b0, 1'b0);       // no enables
    testQuietChange();
    runTicks("R6", 5, 2, 1'b1, 1'b0);
    runTicks("R6", 40, 4, 1'b1, 1'b1);       // rate change mid-period
    runTicks("R4", 300, 1, 1'b1, 1'b1);      // period 128
    runTicks("R4", 520, 2, 1'b1, 1'b0);      // period 256
    runTicks("R3", 20, 1 + 14, 1'b1, 1'b1);  // period 16384 not yet reached
    runTicks("R3", 16384, 15, 1'b0, 1'b1);   // covers one long event
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule